// File: doc/BRIEF.md
# Processor Reset and Clock-Phase Sequencer

This block stands between a raw, active-high system reset and a processor core that runs on a two-phase clock at half the system clock rate. It passes the raw reset through a two-stage synchronizer. It accepts a reset only after the reset has been held for a minimum run of system clocks, so short glitches never restart the core. On every synchronized rising edge of the reset it forces the processor-clock phase back to a known alignment.

Once a qualified reset is released, the block keeps the core in initialization for a fixed number of system clocks. It then issues a one-cycle start strobe that lets the first code fetch go out on the bus, and enables the bus drivers. A new qualified reset at any moment abandons whatever the sequence was doing. All state lives in plain edge-triggered registers, so the system clock may be halted at either level for any length of time without losing anything.

Top module: `reset_phase_seq`

## Requirements
- R1: While a qualified reset is in force, `core_rst` is 1, `bus_oe` is 0 (bus tristated) and `fetch_start` is 0.
- R2: If `rst_in` is sampled high on 17 consecutive system clock edges, `core_rst` rises at the second edge after the 17th high sample. A run of 16 high samples leaves `core_rst`, `bus_oe` and `fetch_start` unchanged.
- R3: A reset held high for any number of cycles, well beyond 17, keeps `core_rst` at 1 for the whole hold; the length counter never wraps.
- R4: After a qualified reset, `core_rst` falls at the second edge after the first edge that samples `rst_in` low.
- R5: `fetch_start` is 1 for exactly one cycle, beginning 50 edges after the edge at which `core_rst` fell. `bus_oe` rises on that same edge and stays 1 until the next qualified reset.
- R6: `phase_two` encodes the processor phase (0 = phase one, 1 = phase two) and inverts on every system clock edge, apart from realignment.
- R7: At the third edge after an edge that samples `rst_in` high following a low sample, `phase_two` is forced to 0. It then alternates, whether or not that pulse qualifies.
- R8: An unqualified pulse (16 samples) arriving during initialization does not move the `fetch_start` edge.
- R9: A qualified reset during initialization or normal running drives `core_rst` back to 1 and `bus_oe` to 0, and cancels the pending `fetch_start`. A fresh 50-cycle count follows its release.
- R10: If qualification and completion of the 50-cycle count fall on the same edge, the reset wins: no `fetch_start` pulse, and `core_rst` is 1 after that edge.
- R11: Halting the system clock for an arbitrary time during initialization loses no state: the `fetch_start` edge, counted in clock edges, is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_in | input | 1 | Raw active-high system reset, may be asynchronous |
| phase_two | output | 1 | Processor clock phase: 0 = phase one, 1 = phase two |
| core_rst | output | 1 | Reset held on the processor core |
| bus_oe | output | 1 | Bus output enable; 0 tristates the bus |
| fetch_start | output | 1 | One-cycle strobe permitting the first code fetch |

## Verification
The two functions that can land on one edge are qualification of a new reset and completion of the initialization count. The bench provokes this by releasing one reset and then raising `rst_in` again 34 edges after the first low sample, so that the 17th-sample qualification lands on the very edge where the 50-cycle count expires. It judges the result by requiring `fetch_start` to stay 0 on that cycle and the next, and `core_rst` to be 1 right after that edge. A second collision, a short pulse during initialization, is judged by the `fetch_start` edge staying exactly where the first release put it.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_INIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

  typedef enum logic {
    PH_ONE = 1'b0,
    PH_TWO = 1'b1
  } proc_phase_e;

endpackage

// File: rtl/rps_sync.sv
// Multi-stage synchronizer for the raw reset input.
module rps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rps_len_qual.sv
// Counts consecutive synchronized reset samples, saturating at the limit,
// and flags the qualifying edge plus each synchronized rising edge.
module rps_len_qual #(
  parameter int HOLD_MIN = 16
) (
  input  logic clk,
  input  logic rst_sync,
  output logic qual_fire,
  output logic rst_rise
);

  localparam int CNT_W = $clog2(HOLD_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HOLD_MIN);

  logic [CNT_W-1:0] run_len;
  logic             rst_prev;

  always_ff @(posedge clk) begin
    rst_prev <= rst_sync;
    if (!rst_sync) begin
      run_len <= '0;
    end else if (run_len != CNT_TOP) begin
      run_len <= run_len + 1'b1;
    end
  end

  // A further high sample once the count has topped out is the qualifying one.
  assign qual_fire = rst_sync && (run_len == CNT_TOP);
  assign rst_rise  = rst_sync && !rst_prev;

endmodule

// File: rtl/rps_phase.sv
// Two-phase processor clock indicator with realignment after a reset edge.
module rps_phase
  import rps_pkg::*;
#(
  parameter int ALIGN_EDGES = 2
) (
  input  logic clk,
  input  logic rst_rise,
  output logic phase_two
);

  localparam int AW = $clog2(ALIGN_EDGES + 1);
  localparam logic [AW-1:0] A_LOAD = AW'(ALIGN_EDGES - 1);

  proc_phase_e      phase_q;
  logic [AW-1:0]    align_cnt;

  always_ff @(posedge clk) begin
    if (rst_rise) begin
      align_cnt <= A_LOAD;
    end else if (align_cnt != '0) begin
      align_cnt <= align_cnt - 1'b1;
    end

    if (!rst_rise && align_cnt == AW'(1)) begin
      phase_q <= PH_ONE;
    end else begin
      phase_q <= (phase_q == PH_ONE) ? PH_TWO : PH_ONE;
    end
  end

  assign phase_two = (phase_q == PH_TWO);

endmodule

// File: rtl/rps_init_seq.sv
// Hold / initialization / run sequencing with registered outputs.
module rps_init_seq
  import rps_pkg::*;
#(
  parameter int INIT_CYC = 50
) (
  input  logic clk,
  input  logic rst_sync,
  input  logic qual_fire,
  output logic core_rst,
  output logic bus_oe,
  output logic fetch_start
);

  localparam int IW = $clog2(INIT_CYC + 1);
  localparam logic [IW-1:0] I_LAST = IW'(INIT_CYC - 1);

  seq_state_e    state_q, state_d;
  logic [IW-1:0] icnt_q, icnt_d;
  logic          fire_d;

  always_comb begin
    state_d = state_q;
    icnt_d  = icnt_q;
    fire_d  = 1'b0;
    if (qual_fire) begin
      // A qualified reset outranks everything, including a count expiring now.
      state_d = SEQ_HOLD;
      icnt_d  = '0;
    end else begin
      case (state_q)
        SEQ_HOLD: begin
          if (!rst_sync) begin
            state_d = SEQ_INIT;
            icnt_d  = '0;
          end
        end
        SEQ_INIT: begin
          if (icnt_q == I_LAST) begin
            state_d = SEQ_RUN;
            fire_d  = 1'b1;
          end else begin
            icnt_d = icnt_q + 1'b1;
          end
        end
        SEQ_RUN: state_d = SEQ_RUN;
        default: state_d = SEQ_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state_q     <= state_d;
    icnt_q      <= icnt_d;
    core_rst    <= (state_d == SEQ_HOLD);
    bus_oe      <= (state_d == SEQ_RUN);
    fetch_start <= fire_d;
  end

endmodule

// File: rtl/reset_phase_seq.sv
module reset_phase_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_MIN    = 16,
  parameter int INIT_CYC    = 50,
  parameter int ALIGN_EDGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic phase_two,
  output logic core_rst,
  output logic bus_oe,
  output logic fetch_start
);

  logic rst_sync;
  logic qual_fire;
  logic rst_rise;

  rps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (rst_in),
    .q   (rst_sync)
  );

  rps_len_qual #(.HOLD_MIN(HOLD_MIN)) u_qual (
    .clk       (clk),
    .rst_sync  (rst_sync),
    .qual_fire (qual_fire),
    .rst_rise  (rst_rise)
  );

  rps_phase #(.ALIGN_EDGES(ALIGN_EDGES)) u_phase (
    .clk       (clk),
    .rst_rise  (rst_rise),
    .phase_two (phase_two)
  );

  rps_init_seq #(.INIT_CYC(INIT_CYC)) u_seq (
    .clk         (clk),
    .rst_sync    (rst_sync),
    .qual_fire   (qual_fire),
    .core_rst    (core_rst),
    .bus_oe      (bus_oe),
    .fetch_start (fetch_start)
  );

endmodule

// File: rtl/reset_phase_seq_chk.sv
module reset_phase_seq_chk #(
  parameter int HOLD_MIN = 16,
  parameter int INIT_CYC = 50
) (
  input logic clk,
  input logic rst_in,
  input logic phase_two,
  input logic core_rst,
  input logic bus_oe,
  input logic fetch_start
);

  localparam int HW = $clog2(HOLD_MIN + 3);
  localparam int RW = $clog2(INIT_CYC + 3);

  logic          seen_rst = 1'b0;
  logic [HW-1:0] hi_cnt   = '0;
  logic [RW-1:0] rel_cnt  = '0;

  always_ff @(posedge clk) begin
    if (core_rst) seen_rst <= 1'b1;
    if (!rst_in) hi_cnt <= '0;
    else if (hi_cnt != HW'(HOLD_MIN + 1)) hi_cnt <= hi_cnt + 1'b1;
    if (core_rst) rel_cnt <= '0;
    else if (rel_cnt != RW'(INIT_CYC + 1)) rel_cnt <= rel_cnt + 1'b1;
  end

  assert_hold_outputs_R1: assert property (@(posedge clk) disable iff (!seen_rst)
    core_rst |-> (!bus_oe && !fetch_start));

  assert_qual_len_R2: assert property (@(posedge clk) disable iff (!seen_rst)
    $rose(core_rst) |-> ($past(hi_cnt, 2) == HW'(HOLD_MIN + 1)));

  assert_release_R4: assert property (@(posedge clk) disable iff (!seen_rst)
    $fell(core_rst) |-> !$past(rst_in, 3));

  assert_fetch_gap_R5: assert property (@(posedge clk) disable iff (!seen_rst)
    fetch_start |-> (rel_cnt == RW'(INIT_CYC)));

  assert_fetch_single_R5: assert property (@(posedge clk) disable iff (!seen_rst)
    fetch_start |=> !fetch_start);

  assert_oe_rise_R5: assert property (@(posedge clk) disable iff (!seen_rst)
    $rose(bus_oe) |-> fetch_start);

  assert_phase_back_R6: assert property (@(posedge clk) disable iff (!seen_rst)
    phase_two |=> !phase_two);

endmodule

bind reset_phase_seq reset_phase_seq_chk #(
  .HOLD_MIN (HOLD_MIN),
  .INIT_CYC (INIT_CYC)
) u_chk (
  .clk         (clk),
  .rst_in      (rst_in),
  .phase_two   (phase_two),
  .core_rst    (core_rst),
  .bus_oe      (bus_oe),
  .fetch_start (fetch_start)
);

// File: tb/tb_reset_phase_seq.sv
module tb_reset_phase_seq;

  logic clk = 1'b0;
  logic clk_stop = 1'b0;
  logic rst_in = 1'b1;
  logic phase_two, core_rst, bus_oe, fetch_start;
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  localparam int S_RST = 0, S_OE = 1, S_FETCH = 2, S_PH = 3;

  typedef struct {
    int    cy;
    int    sig;
    bit    val;
    string req;
  } exp_t;

  exp_t sb[$];

  reset_phase_seq dut (
    .clk         (clk),
    .rst_in      (rst_in),
    .phase_two   (phase_two),
    .core_rst    (core_rst),
    .bus_oe      (bus_oe),
    .fetch_start (fetch_start)
  );

  initial begin
    forever begin
      #2;
      if (!clk_stop) clk = ~clk;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void expect_at(int cy, int sig, bit v, string req);
    exp_t e;
    e.cy = cy; e.sig = sig; e.val = v; e.req = req;
    sb.push_back(e);
  endfunction

  function automatic string sig_name(int s);
    case (s)
      S_RST:   return "core_rst";
      S_OE:    return "bus_oe";
      S_FETCH: return "fetch_start";
      default: return "phase_two";
    endcase
  endfunction

  // Monitor: compares every due expectation against the ports after the edge.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cy <= cyc) begin
        bit act;
        case (sb[i].sig)
          S_RST:   act = core_rst;
          S_OE:    act = bus_oe;
          S_FETCH: act = fetch_start;
          default: act = phase_two;
        endcase
        checks++;
        if (sb[i].cy < cyc || act !== sb[i].val) begin
          failures++;
          $display("FAIL %s cycle %0d %s actual=%0b expected=%0b", sb[i].req,
                   sb[i].cy, sig_name(sb[i].sig), act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  // Expected effects of a qualifying pulse raised at cycle c.
  function automatic void exp_qualify(int c);
    expect_at(c + 18, S_RST, 1'b0, "R2");
    expect_at(c + 19, S_RST, 1'b1, "R2");
    expect_at(c + 19, S_OE, 1'b0, "R1");
    expect_at(c + 19, S_FETCH, 1'b0, "R1");
    expect_at(c + 4, S_PH, 1'b0, "R7");
    expect_at(c + 5, S_PH, 1'b1, "R6");
    expect_at(c + 6, S_PH, 1'b0, "R6");
  endfunction

  // Expected release and fetch timing for a pulse raised at c, held n samples.
  function automatic void exp_release(int c, int n);
    expect_at(c + n + 2, S_RST, 1'b1, "R4");
    expect_at(c + n + 3, S_RST, 1'b0, "R4");
    expect_at(c + n + 52, S_FETCH, 1'b0, "R5");
    expect_at(c + n + 52, S_OE, 1'b0, "R5");
    expect_at(c + n + 53, S_FETCH, 1'b1, "R5");
    expect_at(c + n + 53, S_OE, 1'b1, "R5");
    expect_at(c + n + 54, S_FETCH, 1'b0, "R5");
    expect_at(c + n + 60, S_OE, 1'b1, "R5");
  endfunction

  task automatic drive_pulse(int n);
    rst_in = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    rst_in = 1'b0;
  endtask

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    int c;
    int d;
    // Power-up: reset held from time zero (c = 0).
    expect_at(19, S_RST, 1'b1, "R1");
    expect_at(19, S_OE, 1'b0, "R1");
    expect_at(19, S_FETCH, 1'b0, "R1");
    exp_release(0, 30);
    drive_pulse(30);
    wait_cyc(90);

    // Short pulse while running: ignored apart from phase realignment.
    c = cyc;
    expect_at(c + 4, S_PH, 1'b0, "R7");
    expect_at(c + 5, S_PH, 1'b1, "R7");
    for (int k = 17; k <= 21; k++) begin
      expect_at(c + k, S_RST, 1'b0, "R2");
      expect_at(c + k, S_OE, 1'b1, "R2");
      expect_at(c + k, S_FETCH, 1'b0, "R2");
    end
    drive_pulse(16);
    wait_cyc(130);

    // Exactly 17 samples qualifies.
    c = cyc;
    exp_qualify(c);
    exp_release(c, 17);
    drive_pulse(17);
    wait_cyc(205);

    // Short pulse and a clock halt during initialization.
    c = cyc;
    exp_qualify(c);
    exp_release(c, 30);
    expect_at(c + 83, S_FETCH, 1'b1, "R8");
    expect_at(c + 83, S_FETCH, 1'b1, "R11");
    drive_pulse(30);
    wait_cyc(c + 40);
    d = cyc;
    expect_at(d + 4, S_PH, 1'b0, "R7");
    expect_at(d + 19, S_RST, 1'b0, "R8");
    drive_pulse(16);
    wait_cyc(c + 65);
    clk_stop = 1'b1;
    #1000;
    clk_stop = 1'b0;
    wait_cyc(300);

    // Qualified reset during initialization aborts the count.
    c = cyc;
    expect_at(c + 23, S_RST, 1'b0, "R4");
    drive_pulse(20);
    wait_cyc(c + 40);
    d = cyc;
    expect_at(d + 19, S_RST, 1'b1, "R9");
    expect_at(d + 19, S_OE, 1'b0, "R9");
    expect_at(c + 73, S_FETCH, 1'b0, "R9");
    expect_at(c + 74, S_FETCH, 1'b0, "R9");
    exp_release(d, 20);
    drive_pulse(20);
    wait_cyc(420);

    // Qualification on the very edge the count expires.
    c = cyc;
    expect_at(c + 23, S_RST, 1'b0, "R4");
    drive_pulse(20);
    wait_cyc(c + 54);
    d = cyc;
    expect_at(c + 72, S_RST, 1'b0, "R10");
    expect_at(c + 73, S_RST, 1'b1, "R10");
    expect_at(c + 73, S_FETCH, 1'b0, "R10");
    expect_at(c + 74, S_FETCH, 1'b0, "R10");
    expect_at(c + 74, S_OE, 1'b0, "R10");
    exp_release(d, 25);
    drive_pulse(25);
    wait_cyc(560);

    // Long hold: counter must not wrap.
    c = cyc;
    exp_qualify(c);
    for (int k = 40; k <= 300; k += 37) expect_at(c + k, S_RST, 1'b1, "R3");
    expect_at(c + 302, S_RST, 1'b1, "R3");
    expect_at(c + 200, S_OE, 1'b0, "R3");
    expect_at(c + 104, S_PH, 1'b0, "R6");
    expect_at(c + 105, S_PH, 1'b1, "R6");
    exp_release(c, 300);
    drive_pulse(300);
    wait_cyc(930);

    foreach (sb[i]) begin
      checks++;
      failures++;
      $display("FAIL %s cycle %0d never checked actual=none expected=%0b",
               sb[i].req, sb[i].cy, sb[i].val);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // Watchdog.
  initial begin
    #20000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=cycle %0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule